// File: doc/BRIEF.md
# Prioritized Maskable Interrupt Controller

This block gathers interrupt requests from several sources, qualifies each one against a software-written enable mask and hands the single most urgent survivor to a processor core. It presents that survivor as an index with a valid strobe. The sources are:

- a power-down request;
- a group of external lines whose sensing (rising edge or level) is chosen per line in a control register;
- one external line that is always edge-sensitive;
- a group of external lines that are always level-sensitive.

Each edge-type source owns a pending latch. Software can set or cancel that latch through a write-only force/cancel port.

The core answers a presented interrupt with an acknowledge pulse, which marks that index as in service. A return pulse retires the most urgent interrupt still in service. A nesting enable in the control register decides whether a more urgent request may preempt one already in service. A global enable, raised and dropped by two separate command strobes, gates every presentation, including power-down. For exactly one cycle after any mask write, nothing is presented.

Top module: `irq_prio_ctrl`

## Requirements
- R1: Sources are indexed as follows: power-down is 0, configurable line k is 1+k, the fixed edge line is NCFG+1, and level line j is NCFG+2+j. The lowest qualified index is presented on `int_idx`, with `int_vld` high, in the same cycle.
- R2: Bit i of the mask register (reset value all zeros) enables source i when it is 1. Bit 0 is ignored, so the power-down request is presented whatever the mask holds.
- R3: In the cycle that follows a clock edge on which `msk_wr` was high, `int_vld` is low. The new mask takes effect from that same edge.
- R4: On `cfg_wr`, bit k of `cfg_din` makes configurable line k edge-sensitive (1) or level-sensitive (0), and bit NCFG enables nesting. Both reset to 0. An edge-sensitive source latches a 0-to-1 change of its input as pending.
- R5: A level-sensitive source is requested exactly while its input is high. Acknowledging it does not remove the request.
- R6: On `fc_wr`, a 1 in `fc_set[i]` makes edge-type source i pending and a 1 in `fc_cancel[i]` cancels it. Cancel wins over set, over a new edge and over a held latch. Both have no effect on level-type sources.
- R7: `en_clr` drops the global enable and `en_set` raises it. `en_clr` wins when both are high. The enable is high after reset, and while it is low nothing, including power-down, is presented.
- R8: `core_ack` while `int_vld` is high clears the pending latch of the presented source, if it is edge-type, and marks that index in service. `core_ret` takes the lowest in-service index out of service. A new edge on the same cycle as the acknowledge stays pending.
- R9: With nesting off, nothing is presented while any index is in service. With nesting on, only an index strictly lower than every in-service index is presented.
- R10: After reset, no source is pending or in service and `int_vld` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pd_req | input | 1 | Power-down request, edge-sensitive, index 0 |
| xln_cfg | input | NCFG | External lines with selectable sensing |
| xln_edge | input | 1 | External line, always edge-sensitive |
| xln_lvl | input | NLVL | External lines, always level-sensitive |
| msk_wr | input | 1 | Mask register write strobe |
| msk_din | input | N | Mask write data, bit per source index |
| cfg_wr | input | 1 | Control register write strobe |
| cfg_din | input | NCFG+1 | Sense bits and, at the top, nesting enable |
| fc_wr | input | 1 | Force/cancel write strobe |
| fc_set | input | N | Per-index force-pending bits |
| fc_cancel | input | N | Per-index cancel-pending bits |
| en_set | input | 1 | Global enable command |
| en_clr | input | 1 | Global disable command |
| core_ack | input | 1 | Core accepts the presented interrupt |
| core_ret | input | 1 | Core finishes the most urgent in-service interrupt |
| int_vld | output | 1 | An interrupt is presented |
| int_idx | output | $clog2(N) | Index of the presented interrupt |

## Verification
The bench uses the default build: three configurable lines and two level lines, giving seven sources and a three-bit index. This small build lets a bench sequence reach every source kind, including every flip of a configurable line between edge and level sensing. Nesting chains reach the full source depth, and collisions between force, cancel, edge and acknowledge on one latch occur often under random stimulus. Directed phases set up each corner of sensing, masking, preemption and the enable window before a long random phase.

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl #(
  parameter int NCFG = 3,
  parameter int NLVL = 2,
  localparam int N   = NCFG + NLVL + 2,
  localparam int IDW = $clog2(N)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pd_req,
  input  logic [NCFG-1:0]  xln_cfg,
  input  logic             xln_edge,
  input  logic [NLVL-1:0]  xln_lvl,
  input  logic             msk_wr,
  input  logic [N-1:0]     msk_din,
  input  logic             cfg_wr,
  input  logic [NCFG:0]    cfg_din,
  input  logic             fc_wr,
  input  logic [N-1:0]     fc_set,
  input  logic [N-1:0]     fc_cancel,
  input  logic             en_set,
  input  logic             en_clr,
  input  logic             core_ack,
  input  logic             core_ret,
  output logic             int_vld,
  output logic [IDW-1:0]   int_idx
);

  logic [N-1:0]    mask_q, pend_q, prev_q, insvc_q;
  logic [NCFG-1:0] sense_q;
  logic            nest_q, gie_q, blk_q;

  logic [N-1:0] raw, is_edge, req, qual, ack_oh, ret_oh, set_v, clr_v;
  logic         found;
  logic [IDW:0] low_svc;
  logic         may_present;

  assign raw     = {xln_lvl, xln_edge, xln_cfg, pd_req};
  assign is_edge = {{NLVL{1'b0}}, 1'b1, sense_q, 1'b1};
  assign req     = (is_edge & pend_q) | (~is_edge & raw);
  assign qual    = req & {mask_q[N-1:1], 1'b1};

  always_comb begin
    found   = 1'b0;
    int_idx = '0;
    for (int i = N - 1; i >= 0; i--)
      if (qual[i]) begin
        found   = 1'b1;
        int_idx = IDW'(i);
      end
  end

  always_comb begin
    low_svc = (IDW+1)'(N);
    for (int i = N - 1; i >= 0; i--)
      if (insvc_q[i]) low_svc = (IDW+1)'(i);
  end

  assign may_present = nest_q ? ({1'b0, int_idx} < low_svc) : (insvc_q == '0);
  assign int_vld     = gie_q & ~blk_q & found & may_present;

  assign ack_oh = (core_ack && int_vld) ? ({{(N-1){1'b0}}, 1'b1} << int_idx) : '0;
  assign ret_oh = core_ret ? (insvc_q & (~insvc_q + {{(N-1){1'b0}}, 1'b1})) : '0;
  assign set_v  = fc_wr ? fc_set    : '0;
  assign clr_v  = fc_wr ? fc_cancel : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q  <= '0;
      pend_q  <= '0;
      prev_q  <= '0;
      insvc_q <= '0;
      sense_q <= '0;
      nest_q  <= 1'b0;
      gie_q   <= 1'b1;
      blk_q   <= 1'b0;
    end else begin
      pend_q  <= (((pend_q & ~ack_oh) | (raw & ~prev_q) | set_v) & ~clr_v) & is_edge;
      prev_q  <= raw;
      insvc_q <= (insvc_q & ~ret_oh) | ack_oh;
      blk_q   <= msk_wr;
      if (msk_wr) mask_q <= msk_din;
      if (cfg_wr) begin
        sense_q <= cfg_din[NCFG-1:0];
        nest_q  <= cfg_din[NCFG];
      end
      if (en_clr)      gie_q <= 1'b0;
      else if (en_set) gie_q <= 1'b1;
    end
  end

endmodule

// File: rtl/irq_prio_ctrl_chk.sv
module irq_prio_ctrl_chk #(
  parameter int NCFG = 3,
  parameter int NLVL = 2,
  localparam int N   = NCFG + NLVL + 2,
  localparam int IDW = $clog2(N)
) (
  input logic           clk,
  input logic           rst_n,
  input logic           msk_wr,
  input logic           core_ack,
  input logic           int_vld,
  input logic [IDW-1:0] int_idx,
  input logic           gie_q,
  input logic           nest_q,
  input logic [N-1:0]   insvc_q,
  input logic [N-1:0]   mask_q
);

  // R1
  idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int_vld |-> (int_idx < IDW'(N)));

  // R2
  mask_qual_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int_vld && int_idx != '0) |-> mask_q[int_idx]);

  // R3
  mask_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    msk_wr |=> !int_vld);

  // R7
  global_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !gie_q |-> !int_vld);

  // R8
  ack_service_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int_vld && core_ack) |=> insvc_q[$past(int_idx)]);

  // R9
  nest_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!nest_q && insvc_q != '0) |-> !int_vld);

endmodule

bind irq_prio_ctrl irq_prio_ctrl_chk #(.NCFG(NCFG), .NLVL(NLVL)) u_chk (
  .clk(clk), .rst_n(rst_n), .msk_wr(msk_wr), .core_ack(core_ack),
  .int_vld(int_vld), .int_idx(int_idx), .gie_q(gie_q), .nest_q(nest_q),
  .insvc_q(insvc_q), .mask_q(mask_q)
);

// File: tb/tb_irq_prio_ctrl.sv
module tb_irq_prio_ctrl;
  localparam int NCFG = 3;
  localparam int NLVL = 2;
  localparam int N    = NCFG + NLVL + 2;
  localparam int IDW  = $clog2(N);
  localparam int EDG  = NCFG + 1;
  localparam int LV0  = NCFG + 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pd_req = 0, xln_edge = 0, msk_wr = 0, cfg_wr = 0, fc_wr = 0;
  logic en_set = 0, en_clr = 0, core_ack = 0, core_ret = 0;
  logic [NCFG-1:0] xln_cfg = '0;
  logic [NLVL-1:0] xln_lvl = '0;
  logic [N-1:0]    msk_din = '0, fc_set = '0, fc_cancel = '0;
  logic [NCFG:0]   cfg_din = '0;
  logic            int_vld;
  logic [IDW-1:0]  int_idx;

  always #2.5 clk = ~clk;

  irq_prio_ctrl #(.NCFG(NCFG), .NLVL(NLVL)) dut (
    .clk(clk), .rst_n(rst_n), .pd_req(pd_req), .xln_cfg(xln_cfg),
    .xln_edge(xln_edge), .xln_lvl(xln_lvl), .msk_wr(msk_wr), .msk_din(msk_din),
    .cfg_wr(cfg_wr), .cfg_din(cfg_din), .fc_wr(fc_wr), .fc_set(fc_set),
    .fc_cancel(fc_cancel), .en_set(en_set), .en_clr(en_clr), .core_ack(core_ack),
    .core_ret(core_ret), .int_vld(int_vld), .int_idx(int_idx)
  );

  int n_cmp = 0, n_bad = 0;
  bit finished = 0;
  bit m_pend[N], m_prev[N], m_svc[N], m_mask[N];
  bit m_sense[NCFG];
  bit m_nest, m_gie, m_blk;
  bit exp_v;
  int exp_i;

  function automatic bit src_in(int i);
    if (i == 0) return pd_req;
    if (i <= NCFG) return xln_cfg[i-1];
    if (i == EDG) return xln_edge;
    return xln_lvl[i-LV0];
  endfunction

  function automatic bit src_edge(int i);
    if (i == 0 || i == EDG) return 1;
    if (i <= NCFG) return m_sense[i-1];
    return 0;
  endfunction

  function automatic int lowest_svc();
    for (int i = 0; i < N; i++) if (m_svc[i]) return i;
    return N;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < N; i++) begin
      m_pend[i] = 0; m_prev[i] = 0; m_svc[i] = 0; m_mask[i] = 0;
    end
    for (int k = 0; k < NCFG; k++) m_sense[k] = 0;
    m_nest = 0; m_gie = 1; m_blk = 0;
  endtask

  task automatic predict();
    bit hit = 0;
    int ls;
    exp_i = 0;
    for (int i = 0; i < N; i++) begin
      bit r = src_edge(i) ? m_pend[i] : src_in(i);
      if (!hit && r && (i == 0 || m_mask[i])) begin hit = 1; exp_i = i; end
    end
    ls = lowest_svc();
    exp_v = m_gie && !m_blk && hit && (m_nest ? (exp_i < ls) : (ls == N));
  endtask

  task automatic model_step();
    bit np[N];
    bit acc = core_ack && exp_v;
    int ls = lowest_svc();
    for (int i = 0; i < N; i++) begin
      np[i] = 0;
      if (src_edge(i)) begin
        np[i] = m_pend[i];
        if (acc && exp_i == i) np[i] = 0;
        if (src_in(i) && !m_prev[i]) np[i] = 1;
        if (fc_wr && fc_set[i]) np[i] = 1;
        if (fc_wr && fc_cancel[i]) np[i] = 0;
      end
    end
    for (int i = 0; i < N; i++) begin
      m_pend[i] = np[i];
      m_prev[i] = src_in(i);
    end
    if (core_ret && ls < N) m_svc[ls] = 0;
    if (acc) m_svc[exp_i] = 1;
    m_blk = msk_wr;
    if (msk_wr) for (int i = 0; i < N; i++) m_mask[i] = msk_din[i];
    if (cfg_wr) begin
      for (int k = 0; k < NCFG; k++) m_sense[k] = cfg_din[k];
      m_nest = cfg_din[NCFG];
    end
    if (en_clr) m_gie = 0;
    else if (en_set) m_gie = 1;
  endtask

  task automatic clear_pulses();
    msk_wr = 0; cfg_wr = 0; fc_wr = 0; en_set = 0; en_clr = 0;
    core_ack = 0; core_ret = 0; fc_set = '0; fc_cancel = '0;
  endtask

  // called at a falling edge with inputs applied; returns at the next falling edge
  task automatic cyc(string tag);
    #1;
    predict();
    n_cmp++;
    if (int_vld !== exp_v || (exp_v && int_idx !== IDW'(exp_i))) begin
      n_bad++;
      $display("FAIL %s: vld/idx actual %0b/%0d expected %0b/%0d at %0t",
               tag, int_vld, int_idx, exp_v, exp_i, $time);
    end
    @(posedge clk);
    model_step();
    @(negedge clk);
    clear_pulses();
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    finish_run();
  end

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    // R10 idle after reset
    repeat (3) cyc("R10");
    // R2 power-down ignores the all-zero mask
    pd_req = 1; cyc("R2"); cyc("R2");
    core_ack = 1; cyc("R2");
    pd_req = 0; cyc("R2");
    core_ret = 1; cyc("R2");
    msk_wr = 1; msk_din = '0; cyc("R2");
    cyc("R2");
    // R4 all configurable lines edge-sensitive, nesting off
    cfg_wr = 1; cfg_din = {1'b0, {NCFG{1'b1}}}; cyc("R4");
    msk_wr = 1; msk_din = '1; cyc("R3");
    xln_cfg = 3'b101; cyc("R3");
    cyc("R1");
    core_ack = 1; cyc("R1");
    cyc("R9");
    core_ret = 1; cyc("R8");
    cyc("R1");
    core_ack = 1; xln_cfg = 3'b000; cyc("R8");
    core_ret = 1; cyc("R8");
    // R3 mask write while a request is waiting
    xln_edge = 1; cyc("R3");
    msk_wr = 1; msk_din = '1; cyc("R3");
    cyc("R3");
    // R6 cancel the fixed edge line, force a level source (no effect)
    fc_wr = 1; fc_cancel[EDG] = 1; fc_set[LV0] = 1; cyc("R6");
    cyc("R6");
    fc_wr = 1; fc_set[EDG] = 1; fc_cancel[EDG] = 1; cyc("R6");
    fc_wr = 1; fc_set[2] = 1; cyc("R6");
    cyc("R6");
    fc_wr = 1; fc_cancel = '1; cyc("R6");
    xln_edge = 0;
    // R5 level source stays after acknowledge
    xln_lvl[0] = 1; cyc("R5");
    core_ack = 1; cyc("R5");
    core_ret = 1; cyc("R5");
    cyc("R5");
    xln_lvl[0] = 0; cyc("R5");
    // R4 configurable line 1 to level sensing
    cfg_wr = 1; cfg_din = {1'b0, 3'b101}; cyc("R4");
    xln_cfg[1] = 1; cyc("R4"); cyc("R4");
    xln_cfg[1] = 0; cyc("R4");
    // R7 global disable blocks power-down
    en_clr = 1; cyc("R7");
    pd_req = 1; cyc("R7"); cyc("R7");
    en_set = 1; en_clr = 1; cyc("R7");
    en_set = 1; cyc("R7");
    cyc("R7");
    fc_wr = 1; fc_cancel = '1; pd_req = 0; cyc("R7");
    // R9 nesting on: strictly lower index preempts
    cfg_wr = 1; cfg_din = {1'b1, 3'b111}; cyc("R9");
    xln_cfg[2] = 1; cyc("R9");
    core_ack = 1; cyc("R9");
    xln_lvl[1] = 1; cyc("R9");
    xln_cfg[0] = 1; cyc("R9");
    core_ack = 1; cyc("R9");
    cyc("R9");
    core_ret = 1; cyc("R9");
    core_ret = 1; cyc("R9");
    core_ack = 1; cyc("R9");
    core_ret = 1; xln_lvl = '0; xln_cfg = '0; cyc("R9");
    // R8 random mix of every control
    for (int c = 0; c < 6000; c++) begin
      if ($urandom_range(0, 9) == 0) pd_req = ~pd_req;
      if ($urandom_range(0, 3) == 0) xln_cfg = NCFG'($urandom);
      if ($urandom_range(0, 4) == 0) xln_edge = ~xln_edge;
      if ($urandom_range(0, 7) == 0) xln_lvl = NLVL'($urandom);
      if ($urandom_range(0, 19) == 0) begin msk_wr = 1; msk_din = N'($urandom); end
      if ($urandom_range(0, 29) == 0) begin cfg_wr = 1; cfg_din = (NCFG+1)'($urandom); end
      if ($urandom_range(0, 14) == 0) begin
        fc_wr = 1; fc_set = N'($urandom); fc_cancel = N'($urandom) & N'($urandom);
      end
      if ($urandom_range(0, 29) == 0) en_clr = 1;
      if ($urandom_range(0, 7) == 0) en_set = 1;
      core_ack = ($urandom_range(0, 1) == 0);
      core_ret = ($urandom_range(0, 4) == 0);
      cyc("R8");
    end
    finish_run();
  end
endmodule